// File: doc/BRIEF.md
# Partitioned Slot Allocator

This block hands out slots from a fixed pool of message slots that receive traffic and transmit traffic share. Each slot has one busy flag. A requester presents an allocation request tagged with a category, receive or transmit, and gets back a response with a slot index and a success flag, or a failure with the category echoed. A free request names a slot and clears its busy flag. The lowest quarter of the pool can only be granted to receive requests. Transmit requests search from the quarter point upward, so a reply from the far side always has somewhere to land even when transmit traffic has filled everything it can reach.

A single scratch slot sits outside the pool. It is claimed with a plain strobe and released through the free port. Releasing it never counts as an error, even when it is already free. A free aimed at a pool slot that is already free changes nothing and sets a sticky error flag. Two live counts report how many busy slots lie in the receive-only quarter and how many in the shared upper region.

The allocation path is a valid/ready stream. A request is taken on a clock edge where `alloc_valid` and `alloc_ready` are both high. `alloc_ready` is high whenever no response is waiting or the waiting response is taken in that cycle. A response stays on its pins unchanged until `resp_valid` and `resp_ready` are both high. The free port and the scratch claim are plain single-cycle strobes with no back-pressure.

Top module: `slot_pool_alloc`

## Requirements
- R1: After reset no slot and no scratch slot is busy, both counts are 0, the error flag is 0, `resp_valid` is 0 and `alloc_ready` is 1.
- R2: A receive request (`alloc_cat`=0) is granted the lowest-numbered free slot in the whole pool, searching from index 0 up to POOL_SIZE-1.
- R3: A transmit request (`alloc_cat`=1) is granted the lowest-numbered free slot at or above index POOL_SIZE/4, and is never given a slot below that index.
- R4: When no eligible slot is free, the response has `resp_ok`=0 and `resp_cat` equal to the requested category. A transmit request fails even while slots in the lower quarter are free.
- R5: A granted slot becomes busy in the same edge that takes the request, so it is never granted again until it is freed.
- R6: A free with `free_scratch`=0 clears the busy flag of slot `free_idx`, and a later request can be granted that slot.
- R7: When a free and an accepted request fall on the same edge, the free is applied first, so the request can be granted the slot being freed.
- R8: A free of a pool slot that is already free leaves every busy flag unchanged and sets `dbl_free_err`, which stays 1 until reset.
- R9: `scratch_take` marks the scratch slot busy. A free with `free_scratch`=1 clears it, never sets the error flag, and leaves every pool slot unchanged whatever `free_idx` holds.
- R10: `rx_busy_cnt` equals the number of busy slots below POOL_SIZE/4, and `tx_busy_cnt` equals the number of busy slots at or above it.
- R11: While `resp_valid` is 1 and `resp_ready` is 0, `alloc_ready` is 0 and `resp_ok`, `resp_idx` and `resp_cat` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Allocation request present |
| alloc_ready | output | 1 | Request can be taken this cycle |
| alloc_cat | input | 1 | Category: 0 receive, 1 transmit |
| resp_valid | output | 1 | Allocation response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_ok | output | 1 | 1 when a slot was granted |
| resp_cat | output | 1 | Category of the answered request |
| resp_idx | output | $clog2(POOL_SIZE) | Granted slot index, 0 on failure |
| free_valid | input | 1 | Free strobe |
| free_scratch | input | 1 | Free targets the scratch slot |
| free_idx | input | $clog2(POOL_SIZE) | Pool slot to free |
| scratch_take | input | 1 | Mark the scratch slot busy |
| scratch_busy | output | 1 | Scratch slot busy flag |
| dbl_free_err | output | 1 | Sticky: a free pool slot was freed |
| rx_busy_cnt | output | $clog2(POOL_SIZE/4+1) | Busy slots in the receive-only quarter |
| tx_busy_cnt | output | $clog2(POOL_SIZE-POOL_SIZE/4+1) | Busy slots in the shared region |

## Verification
A free and an allocation can land on the same edge. The bench provokes this in two ways. It frees a slot in the shared region while every slot is busy, and requires the receive request on that edge to get exactly that slot. It also frees a lower-quarter slot alongside a transmit request, and requires the request to fail, because the freed slot lies below the transmit search start. In both cases the scoreboard's expected response comes from a model that applies the free before the search, and the region counts are compared after the edge.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  typedef enum logic {
    CAT_RX = 1'b0,
    CAT_TX = 1'b1
  } slot_cat_e;
endpackage

// File: rtl/slot_finder.sv
// Lowest free slot at or above index LO.
module slot_finder #(
  parameter int N     = 16,
  parameter int LO    = 0,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     busy,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= LO; i--) begin
      if (!busy[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/region_count.sv
// Population count of busy flags in [LO, HI].
module region_count #(
  parameter int N   = 16,
  parameter int LO  = 0,
  parameter int HI  = 3,
  parameter int W   = $clog2(HI - LO + 2)
) (
  input  logic [N-1:0] busy,
  output logic [W-1:0] count
);
  always_comb begin
    count = '0;
    for (int i = LO; i <= HI; i++) begin
      count = count + W'(busy[i]);
    end
  end
endmodule

// File: rtl/slot_pool_alloc.sv
module slot_pool_alloc #(
  parameter int POOL_SIZE = 16,
  localparam int QUARTER  = POOL_SIZE / 4,
  localparam int IDX_W    = $clog2(POOL_SIZE),
  localparam int RXC_W    = $clog2(QUARTER + 1),
  localparam int TXC_W    = $clog2(POOL_SIZE - QUARTER + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  output logic             alloc_ready,
  input  logic             alloc_cat,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic             resp_ok,
  output logic             resp_cat,
  output logic [IDX_W-1:0] resp_idx,
  input  logic             free_valid,
  input  logic             free_scratch,
  input  logic [IDX_W-1:0] free_idx,
  input  logic             scratch_take,
  output logic             scratch_busy,
  output logic             dbl_free_err,
  output logic [RXC_W-1:0] rx_busy_cnt,
  output logic [TXC_W-1:0] tx_busy_cnt
);
  import slot_alloc_pkg::*;

  if (POOL_SIZE < 4 || (POOL_SIZE % 4) != 0) begin : g_bad_size
    $error("POOL_SIZE must be a multiple of 4 and at least 4");
  end

  logic [POOL_SIZE-1:0] busy_q;
  logic [POOL_SIZE-1:0] free_clr;
  logic [POOL_SIZE-1:0] busy_after_free;
  logic [POOL_SIZE-1:0] grant_set;
  logic                 pool_free_req;
  logic                 free_hit;
  logic                 accept;
  slot_cat_e            req_cat;

  logic             rx_found, tx_found, sel_found;
  logic [IDX_W-1:0] rx_idx, tx_idx, sel_idx;

  // Free decode: a one-hot clear mask, empty for the scratch slot.
  assign pool_free_req = free_valid && !free_scratch;

  always_comb begin
    for (int i = 0; i < POOL_SIZE; i++) begin
      free_clr[i] = pool_free_req && (free_idx == IDX_W'(i));
    end
  end

  assign free_hit        = |(busy_q & free_clr);
  assign busy_after_free = busy_q & ~free_clr;

  // Two searches over the post-free view: the whole pool and the shared region.
  slot_finder #(.N(POOL_SIZE), .LO(0), .IDX_W(IDX_W)) u_find_rx (
    .busy  (busy_after_free),
    .found (rx_found),
    .idx   (rx_idx)
  );

  slot_finder #(.N(POOL_SIZE), .LO(QUARTER), .IDX_W(IDX_W)) u_find_tx (
    .busy  (busy_after_free),
    .found (tx_found),
    .idx   (tx_idx)
  );

  assign req_cat   = slot_cat_e'(alloc_cat);
  assign sel_found = (req_cat == CAT_TX) ? tx_found : rx_found;
  assign sel_idx   = (req_cat == CAT_TX) ? tx_idx : rx_idx;

  assign alloc_ready = !resp_valid || resp_ready;
  assign accept      = alloc_valid && alloc_ready;

  always_comb begin
    for (int i = 0; i < POOL_SIZE; i++) begin
      grant_set[i] = accept && sel_found && (sel_idx == IDX_W'(i));
    end
  end

  // Busy flags: the free clears first, then the grant sets in the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else begin
      busy_q <= busy_after_free | grant_set;
    end
  end

  // Response stage held under back-pressure.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_ok    <= 1'b0;
      resp_cat   <= 1'b0;
      resp_idx   <= '0;
    end else if (accept) begin
      resp_valid <= 1'b1;
      resp_ok    <= sel_found;
      resp_cat   <= alloc_cat;
      resp_idx   <= sel_found ? sel_idx : '0;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

  // Scratch slot: a release and a claim on one edge leave it claimed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scratch_busy <= 1'b0;
    end else if (scratch_take) begin
      scratch_busy <= 1'b1;
    end else if (free_valid && free_scratch) begin
      scratch_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbl_free_err <= 1'b0;
    end else if (pool_free_req && !free_hit) begin
      dbl_free_err <= 1'b1;
    end
  end

  region_count #(.N(POOL_SIZE), .LO(0), .HI(QUARTER - 1), .W(RXC_W)) u_cnt_rx (
    .busy  (busy_q),
    .count (rx_busy_cnt)
  );

  region_count #(.N(POOL_SIZE), .LO(QUARTER), .HI(POOL_SIZE - 1), .W(TXC_W)) u_cnt_tx (
    .busy  (busy_q),
    .count (tx_busy_cnt)
  );
endmodule

// File: rtl/slot_pool_alloc_chk.sv
module slot_pool_alloc_chk #(
  parameter int POOL_SIZE = 16,
  localparam int QUARTER  = POOL_SIZE / 4,
  localparam int IDX_W    = $clog2(POOL_SIZE),
  localparam int RXC_W    = $clog2(QUARTER + 1),
  localparam int TXC_W    = $clog2(POOL_SIZE - QUARTER + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 alloc_valid,
  input logic                 alloc_ready,
  input logic                 resp_valid,
  input logic                 resp_ready,
  input logic                 resp_ok,
  input logic                 resp_cat,
  input logic [IDX_W-1:0]     resp_idx,
  input logic                 free_valid,
  input logic                 free_scratch,
  input logic                 scratch_take,
  input logic                 scratch_busy,
  input logic                 dbl_free_err,
  input logic [RXC_W-1:0]     rx_busy_cnt,
  input logic [TXC_W-1:0]     tx_busy_cnt,
  input logic [POOL_SIZE-1:0] busy_q
);
  // Set when the response on the pins was loaded by the last edge.
  logic fresh_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fresh_q <= 1'b0;
    else        fresh_q <= alloc_valid && alloc_ready;
  end

  assert_tx_above_quarter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_ok && resp_cat |-> resp_idx >= IDX_W'(QUARTER));

  assert_rx_fail_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_q && !resp_ok && !resp_cat |-> &busy_q);

  assert_tx_fail_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_q && !resp_ok && resp_cat |-> &busy_q[POOL_SIZE-1:QUARTER]);

  assert_grant_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_q && resp_ok |-> busy_q[resp_idx]);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_free_err |=> dbl_free_err);

  assert_scratch_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid && free_scratch && !scratch_take |=> !scratch_busy);

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy_cnt <= RXC_W'(QUARTER)) && (tx_busy_cnt <= TXC_W'(POOL_SIZE - QUARTER)));

  assert_hold_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_idx) && $stable(resp_ok) && $stable(resp_cat));

  assert_ready_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |-> !alloc_ready);
endmodule

bind slot_pool_alloc slot_pool_alloc_chk #(.POOL_SIZE(POOL_SIZE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .resp_valid   (resp_valid),
  .resp_ready   (resp_ready),
  .resp_ok      (resp_ok),
  .resp_cat     (resp_cat),
  .resp_idx     (resp_idx),
  .free_valid   (free_valid),
  .free_scratch (free_scratch),
  .scratch_take (scratch_take),
  .scratch_busy (scratch_busy),
  .dbl_free_err (dbl_free_err),
  .rx_busy_cnt  (rx_busy_cnt),
  .tx_busy_cnt  (tx_busy_cnt),
  .busy_q       (busy_q)
);

// File: tb/test_slot_pool_alloc.sv
`timescale 1ns/1ps
module test_slot_pool_alloc;
  localparam int N  = 16;
  localparam int Q  = N / 4;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0, alloc_cat = 1'b0, resp_ready = 1'b1;
  logic free_valid = 1'b0, free_scratch = 1'b0, scratch_take = 1'b0;
  logic [IW-1:0] free_idx = '0;
  logic alloc_ready, resp_valid, resp_ok, resp_cat, scratch_busy, dbl_free_err;
  logic [IW-1:0] resp_idx;
  logic [$clog2(Q+1)-1:0]   rx_busy_cnt;
  logic [$clog2(N-Q+1)-1:0] tx_busy_cnt;

  always #2.5 clk = ~clk;

  slot_pool_alloc #(.POOL_SIZE(N)) i_slot_pool_alloc (
    .clk, .rst_n, .alloc_valid, .alloc_ready, .alloc_cat, .resp_valid,
    .resp_ready, .resp_ok, .resp_cat, .resp_idx, .free_valid, .free_scratch,
    .free_idx, .scratch_take, .scratch_busy, .dbl_free_err, .rx_busy_cnt,
    .tx_busy_cnt
  );

  typedef struct { bit ok; bit tx; int idx; string req; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;

  bit m_busy[N];
  bit m_err = 0;
  bit m_scr = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected responses as the design hands them over.
  always @(negedge clk) begin
    #1;
    if (rst_n && resp_valid && resp_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(resp_ok == e.ok, {e.req, " ok"}, int'(resp_ok), int'(e.ok));
        check(resp_cat == e.tx, {e.req, " category"}, int'(resp_cat), int'(e.tx));
        if (e.ok) check(int'(resp_idx) == e.idx, {e.req, " index"}, int'(resp_idx), e.idx);
      end
    end
  end

  function automatic int cnt_rx();
    int c = 0;
    for (int i = 0; i < Q; i++) c += int'(m_busy[i]);
    return c;
  endfunction

  function automatic int cnt_tx();
    int c = 0;
    for (int i = Q; i < N; i++) c += int'(m_busy[i]);
    return c;
  endfunction

  // Applies free then allocation to the model, pushes the expected response.
  task automatic model_step(input bit a_en, input bit a_tx, input bit f_en, input int f_idx,
                            input bit f_scr, input bit s_take, input string req);
    if (f_en) begin
      if (f_scr) m_scr = 0;
      else if (m_busy[f_idx]) m_busy[f_idx] = 0;
      else m_err = 1;
    end
    if (s_take) m_scr = 1;
    if (a_en) begin
      exp_t e;
      e.ok = 0; e.tx = a_tx; e.idx = 0; e.req = req;
      for (int i = (a_tx ? Q : 0); i < N; i++) begin
        if (!e.ok && !m_busy[i]) begin e.ok = 1; e.idx = i; end
      end
      if (e.ok) m_busy[e.idx] = 1;
      exp_q.push_back(e);
    end
  endtask

  task automatic op(input bit a_en, input bit a_tx, input bit f_en, input int f_idx,
                    input bit f_scr, input bit s_take, input string req);
    @(negedge clk);
    alloc_valid = a_en; alloc_cat = a_tx; free_valid = f_en;
    free_idx = IW'(f_idx); free_scratch = f_scr; scratch_take = s_take;
    model_step(a_en, a_tx, f_en, f_idx, f_scr, s_take, req);
    @(negedge clk);
    alloc_valid = 0; free_valid = 0; free_scratch = 0; scratch_take = 0;
    #1;
  endtask

  task automatic check_state(input string req);
    check(int'(rx_busy_cnt) == cnt_rx(), {req, " rx_busy_cnt"}, int'(rx_busy_cnt), cnt_rx());
    check(int'(tx_busy_cnt) == cnt_tx(), {req, " tx_busy_cnt"}, int'(tx_busy_cnt), cnt_tx());
    check(dbl_free_err == m_err, {req, " dbl_free_err"}, int'(dbl_free_err), int'(m_err));
    check(scratch_busy == m_scr, {req, " scratch_busy"}, int'(scratch_busy), int'(m_scr));
  endtask

  task automatic run_tests();
    int held_idx;
    foreach (m_busy[i]) m_busy[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(resp_valid == 0, "R1 resp_valid", int'(resp_valid), 0);
    check(alloc_ready == 1, "R1 alloc_ready", int'(alloc_ready), 1);
    check_state("R1");

    // R2 receive grants from the bottom
    op(1, 0, 0, 0, 0, 0, "R2 rx first");
    op(1, 0, 0, 0, 0, 0, "R2 rx second");
    check_state("R10 after rx");
    // R3 transmit starts at the quarter point
    op(1, 1, 0, 0, 0, 0, "R3 tx first");
    for (int k = 0; k < N - Q - 1; k++) op(1, 1, 0, 0, 0, 0, "R3 tx fill");
    // R4 transmit fails with lower slots still free
    op(1, 1, 0, 0, 0, 0, "R4 tx fail lower free");
    check_state("R10 tx full");
    op(1, 0, 0, 0, 0, 0, "R2 rx third");
    op(1, 0, 0, 0, 0, 0, "R2 rx fourth");
    op(1, 0, 0, 0, 0, 0, "R4 rx fail pool full");
    check_state("R5 pool full");

    // R6 free then re-grant
    op(0, 0, 1, 7, 0, 0, "R6 free");
    check_state("R6 after free");
    op(1, 1, 0, 0, 0, 0, "R6 tx regrant");
    // R7 same-edge free and receive allocation
    op(1, 0, 1, 9, 0, 0, "R7 rx gets freed slot");
    check_state("R7 counts");
    // R3/R7 lower slot freed alongside a transmit request
    op(1, 1, 1, 1, 0, 0, "R3 tx never below quarter");
    check_state("R3 counts");
    op(1, 0, 0, 0, 0, 0, "R2 rx takes lower slot");

    // R9 scratch slot
    op(0, 0, 0, 0, 0, 1, "R9 take");
    check_state("R9 taken");
    op(0, 0, 1, 5, 1, 0, "R9 release");
    check_state("R9 released pool untouched");
    op(0, 0, 1, 5, 1, 0, "R9 release again");
    check_state("R9 no error");

    // R11 back-pressure
    op(0, 0, 1, 10, 0, 0, "R6 free 10");
    op(0, 0, 1, 11, 0, 0, "R6 free 11");
    @(negedge clk); resp_ready = 0;
    op(1, 1, 0, 0, 0, 0, "R11 first response");
    held_idx = int'(resp_idx);
    check(resp_valid == 1, "R11 resp_valid held", int'(resp_valid), 1);
    @(negedge clk);
    alloc_valid = 1; alloc_cat = 1;
    #1;
    check(alloc_ready == 0, "R11 alloc_ready low", int'(alloc_ready), 0);
    @(negedge clk); #1;
    check(int'(resp_idx) == held_idx, "R11 resp_idx stable", int'(resp_idx), held_idx);
    check(alloc_ready == 0, "R11 still not ready", int'(alloc_ready), 0);
    model_step(1, 1, 0, 0, 0, 0, "R11 second response");
    @(negedge clk); resp_ready = 1;
    @(negedge clk); alloc_valid = 0;
    #2;
    check(exp_q.size() == 0, "R11 both responses delivered", exp_q.size(), 0);

    // R8 double free
    op(0, 0, 1, 10, 0, 0, "R8 good free");
    check_state("R8 before");
    op(0, 0, 1, 10, 0, 0, "R8 double free");
    check_state("R8 error set");
    op(0, 0, 1, 11, 0, 0, "R8 later free");
    check_state("R8 error sticky");
    op(1, 0, 0, 0, 0, 0, "R2 rx lowest overall");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule